// File: doc/BRIEF.md
# Periodic Event Rate Generator

This block turns a 32.768 kHz time-base enable into a programmable stream of periodic event strobes. A 15-bit counter advances by one on every time-base tick and never stops. An event is produced on the tick that brings the counter to an exact multiple of the selected power-of-two period. Events therefore stay locked to the absolute time base. Changing the rate does not restart the period; the next event lands on the next multiple of the new period.

The rate is chosen by a 4-bit code, and a separate enable gates the events. Code zero turns the events off. Codes 3 to 15 select a period of 2^(code-1) ticks. Codes 1 and 2 are shorthand for codes 8 and 9. The only output is a strobe one system clock wide. Whatever consumes it keeps any flag or interrupt state.

Top module: `periodic_event_gen`

## Requirements
- R1: After reset the strobe is low and the tick counter is zero, so with code 3 enabled the first event follows the 4th tick.
- R2: The counter increases by exactly one per tick (modulo 2^15) and holds between ticks; it wraps from 32767 to 0, and 0 counts as a multiple of every period.
- R3: For codes 3 through 15 an event occurs on each tick after which the counter is a multiple of 2^(code-1) ticks (code 3 gives 4 ticks, code 15 gives 16384 ticks).
- R4: Code 1 behaves as code 8 (128 ticks) and code 2 behaves as code 9 (256 ticks).
- R5: Code 0 produces no events whatever the enable.
- R6: With the enable low no event is produced for any code.
- R7: After a rate change the next event occurs when the counter reaches the next multiple of the new period, not a full new period after the change.
- R8: Code and enable are used as they stand in the cycle of each tick. Changing either one produces no event of its own at the moment of the change.
- R9: The strobe rises in the system clock cycle after the qualifying tick and stays high for exactly one cycle.
- R10: No strobe occurs in a cycle that does not follow a tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_32k | input | 1 | One-cycle enable at the 32.768 kHz rate |
| rate_code | input | 4 | Rate select: 0 off, 1 and 2 alias to 8 and 9, n gives 2^(n-1) ticks |
| irq_en | input | 1 | Periodic event enable |
| event_strobe | output | 1 | One-cycle periodic event |

## Verification
There is one register between a tick and the strobe. The result of a tick driven at a falling edge appears right after the next rising edge. The driver pushes one expected strobe value into the scoreboard at every falling edge, including cycles without a tick, where the expected value is 0. The monitor pops one item 1 ns after each rising edge, so each item is compared in the cycle its result is due. Rate changes and enable toggles are applied at the falling edge before a tick, and the bench's own counter model decides where the next multiple falls.

// File: rtl/pit_pkg.sv
package pit_pkg;

  localparam int CNT_W_DEF   = 15;
  localparam int CODE_W_DEF  = 4;
  localparam logic [3:0] ALIAS_ONE_SHIFT = 4'd7;
  localparam logic [3:0] ALIAS_TWO_SHIFT = 4'd8;

  // number of low counter bits that must be zero at an event
  function automatic logic [3:0] rate_shift(input logic [3:0] code);
    logic [3:0] s;
    case (code)
      4'd0:    s = 4'd0;
      4'd1:    s = ALIAS_ONE_SHIFT;
      4'd2:    s = ALIAS_TWO_SHIFT;
      default: s = code - 4'd1;
    endcase
    return s;
  endfunction

  function automatic logic rate_enabled(input logic [3:0] code, input logic en);
    return en && (code != 4'd0);
  endfunction

endpackage

// File: rtl/pit_rate_decode.sv
module pit_rate_decode #(
  parameter int CNT_W  = pit_pkg::CNT_W_DEF,
  parameter int CODE_W = pit_pkg::CODE_W_DEF
) (
  input  logic [CODE_W-1:0] code,
  input  logic              en,
  output logic              active,
  output logic [CNT_W-1:0]  mask
);
  localparam int SH_W = $clog2(CNT_W);

  logic [SH_W-1:0] shift;

  always_comb begin
    shift  = SH_W'(pit_pkg::rate_shift(4'(code)));
    active = pit_pkg::rate_enabled(4'(code), en);
  end

  // a bit is inside the period mask when its index is below the shift
  for (genvar i = 0; i < CNT_W; i++) begin : g_mask
    assign mask[i] = (SH_W'(i) < shift);
  end
endmodule

// File: rtl/pit_tick_counter.sv
module pit_tick_counter #(
  parameter int CNT_W = pit_pkg::CNT_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt_now,
  output logic [CNT_W-1:0] cnt_next
);
  assign cnt_next = cnt_now + CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_now <= '0;
    else if (tick) cnt_now <= cnt_next;
  end

  assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> cnt_now == $past(cnt_now) + CNT_W'(1));

  assert_count_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt_now));
endmodule

// File: rtl/pit_event_detect.sv
module pit_event_detect #(
  parameter int CNT_W = pit_pkg::CNT_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             active,
  input  logic [CNT_W-1:0] mask,
  input  logic [CNT_W-1:0] cnt_next,
  input  logic [CNT_W-1:0] cnt_now,
  output logic             strobe
);
  logic fire_point;

  assign fire_point = tick && active && ((cnt_next & mask) == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strobe <= 1'b0;
    else        strobe <= fire_point;
  end

  assert_aligned_R7: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |-> ((cnt_now & $past(mask)) == '0));

  assert_after_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |-> $past(tick));

  assert_single_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> !strobe);

  assert_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |-> $past(active));
endmodule

// File: rtl/periodic_event_gen.sv
module periodic_event_gen #(
  parameter int CNT_W  = pit_pkg::CNT_W_DEF,
  parameter int CODE_W = pit_pkg::CODE_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_32k,
  input  logic [CODE_W-1:0] rate_code,
  input  logic              irq_en,
  output logic              event_strobe
);
  logic             rate_active;
  logic [CNT_W-1:0] period_mask;
  logic [CNT_W-1:0] cnt_now;
  logic [CNT_W-1:0] cnt_next;

  pit_rate_decode #(.CNT_W(CNT_W), .CODE_W(CODE_W)) u_decode (
    .code   (rate_code),
    .en     (irq_en),
    .active (rate_active),
    .mask   (period_mask)
  );

  pit_tick_counter #(.CNT_W(CNT_W)) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick_32k),
    .cnt_now  (cnt_now),
    .cnt_next (cnt_next)
  );

  pit_event_detect #(.CNT_W(CNT_W)) u_detect (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick_32k),
    .active   (rate_active),
    .mask     (period_mask),
    .cnt_next (cnt_next),
    .cnt_now  (cnt_now),
    .strobe   (event_strobe)
  );

  assert_code_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    event_strobe |-> $past(rate_code) != '0);

  assert_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    event_strobe |-> $past(irq_en));
endmodule

// File: tb/sim_periodic_event_gen.sv
module sim_periodic_event_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_32k = 1'b0;
  logic [3:0] rate_code = 4'd0;
  logic       irq_en = 1'b0;
  logic       event_strobe;

  int checks = 0;
  int fails = 0;
  int bcnt = 0;
  int cycles = 0;
  bit exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  periodic_event_gen u0 (
    .clk(clk), .rst_n(rst_n), .tick_32k(tick_32k),
    .rate_code(rate_code), .irq_en(irq_en), .event_strobe(event_strobe)
  );

  function automatic int period_of(input int code);
    if (code == 1) return 128;
    if (code == 2) return 256;
    return 1 << (code - 1);
  endfunction

  // drive one cycle and predict its strobe
  task automatic step(input bit tk, input int code, input bit en, input string tag);
    bit e;
    @(negedge clk);
    tick_32k  = tk;
    rate_code = 4'(code);
    irq_en    = en;
    e = 1'b0;
    if (tk) begin
      bcnt = (bcnt + 1) % 32768;
      if (en && code != 0 && (bcnt % period_of(code)) == 0) e = 1'b1;
    end
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic run(input int n, input int code, input bit en, input string tag);
    for (int i = 0; i < n; i++) step(1'b1, code, en, tag);
  endtask

  // monitor: one comparison per cycle, just after the rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        bit e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (event_strobe !== e) begin
          fails++;
          $display("FAIL %s: strobe=%0b expected=%0b (model count %0d)", t, event_strobe, e, bcnt);
        end
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 190000) begin
        fails++;
        $display("FAIL watchdog: cycles=%0d expected completion", cycles);
        $display("%0d/%0d checks passed", checks - fails + 1, checks + 1);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (event_strobe !== 1'b0) begin
      fails++;
      $display("FAIL R1: strobe=%0b expected=0 in reset", event_strobe);
    end
    @(negedge clk);
    rst_n = 1'b1;
    // R1 R3 R10: code 3 from zero, ticks spaced by idle cycles
    for (int i = 0; i < 12; i++) begin
      step(1'b1, 3, 1'b1, "R1/R3");
      step(1'b0, 3, 1'b1, "R10");
      step(1'b0, 3, 1'b1, "R10");
    end
    // R4: aliased codes
    run(300, 1, 1'b1, "R4 code1");
    run(600, 2, 1'b1, "R4 code2");
    // R3: each direct code
    for (int c = 4; c <= 14; c++) run(2 * period_of(c) + 3, c, 1'b1, "R3");
    // R2 R3: code 15 across the counter wrap
    run(33000, 15, 1'b1, "R2/R3 code15");
    // R5 and R6
    run(100, 0, 1'b1, "R5");
    run(100, 3, 1'b0, "R6");
    // R7: align to an odd phase, then change the rate mid-period
    run(21, 6, 1'b1, "R7");
    run(40, 4, 1'b1, "R7");
    run(19, 7, 1'b1, "R7");
    run(70, 5, 1'b1, "R7");
    // R8: enable and code toggled between ticks, off-multiple
    run(3, 3, 1'b0, "R8");
    step(1'b0, 3, 1'b1, "R8");
    step(1'b0, 5, 1'b1, "R8");
    run(40, 3, 1'b1, "R8");
    step(1'b0, 0, 1'b0, "R8");
    step(1'b0, 4, 1'b1, "R8");
    // R9: continuous ticks at the fastest rate
    run(64, 3, 1'b1, "R9");
    step(1'b0, 3, 1'b1, "R9");
    step(1'b0, 3, 1'b1, "R9");
    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule